// File: doc/BRIEF.md
# Fixed-Base Modular Power Sequencer

This block raises a fixed base to an exponent modulo a fixed odd or even modulus: given an exponent `x` of twice the modulus width, it produces `BASE^x mod MODULUS`. The base and the modulus are elaboration-time parameters. The per-stage constants `BASE^(2^i) mod MODULUS` and their modular inverses are derived from those parameters while the design elaborates. No gates are spent on computing them. The base must be coprime to the modulus, so that every stage constant has an inverse.

The block walks the exponent one bit per stage, least significant first. A working value starts at one. In each stage a shift-and-add multiplier forms the controlled product: the working value times the stage constant when the exponent bit is set, and the working value unchanged when the bit is clear. The product and the working value then trade places, so the old value sits in a scratch register. A second controlled multiply by the inverse constant rebuilds the old value, and subtracting it modulo the modulus returns the scratch register to zero. Each stage reports its scratch value through a strobe. A single done pulse marks the last stage.

A caller pulses `start` with the exponent while the block is idle. It then waits for `done` and reads `result`, which holds until the next accepted start.

Top module: `mexp_top`

## Requirements
- R1: After reset, `busy`, `done` and `step_valid` are low, and `result` and `scratch` both read 0.
- R2: When `done` is high, `result` equals `BASE^x mod MODULUS` for the exponent captured at start. Exponent 0 gives 1, and the all-ones exponent is handled like any other.
- R3: A run raises `step_valid` exactly `2*MOD_W` times. `done` is high in the same cycle as the last strobe and in no other cycle.
- R4: Whenever `step_valid` is high, `scratch` is 0.
- R5: A `start` pulse while `busy` is high is ignored. The running computation finishes with the exponent it captured, and it produces one `done`.
- R6: The number of cycles from an accepted start to `done` is the same for every exponent value.
- R7: `busy` rises in the cycle after an accepted start and is low in the cycle `done` is high.
- R8: `result` and `scratch` are always below `MODULUS`.
- R9: While idle with no start, `result` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run with `exponent`; honoured only when idle |
| exponent | input | 2*MOD_W | Exponent, bit 0 handled in the first stage |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: `result` is final |
| result | output | MOD_W | Working value; the modular power after `done` |
| step_valid | output | 1 | One-cycle pulse at the end of each stage |
| scratch | output | MOD_W | Scratch register, valid with `step_valid` |

## Verification
The bench builds two copies of the block. The first uses a 4-bit modulus of 15 with base 7, which makes all 256 eight-bit exponents cheap to sweep exhaustively. The second uses a 5-bit modulus of 21 with base 5, which gives ten stages and a stage count that is not a power of two. A table of ten-bit exponents, including the zero, all-ones and single-bit corners, checks that copy's stage indexing, its constant selection and its inverse-based clearing.

// File: rtl/mexp_pkg.sv
package mexp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FWD,
        PH_BACK
    } phase_e;

    // BASE^(2^stage) mod m, by repeated squaring at elaboration time
    function automatic longint stage_const(input longint base, input int stage, input longint m);
        longint c;
        c = base % m;
        for (int k = 0; k < stage; k++) begin
            c = (c * c) % m;
        end
        return c;
    endfunction

    // Multiplicative inverse modulo m (extended Euclid); a must be coprime to m
    function automatic longint inv_mod(input longint a, input longint m);
        longint r0, r1, t0, t1, q, tmp;
        r0 = m;
        r1 = a % m;
        t0 = 0;
        t1 = 1;
        while (r1 != 0) begin
            q   = r0 / r1;
            tmp = r0 - q * r1;
            r0  = r1;
            r1  = tmp;
            tmp = t0 - q * t1;
            t0  = t1;
            t1  = tmp;
        end
        if (t0 < 0) t0 = t0 + m;
        return t0;
    endfunction

endpackage

// File: rtl/mexp_modadd.sv
module mexp_modadd #(
    parameter int W       = 4,
    parameter int MODULUS = 15
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    localparam int SW = W + 1;

    logic [W:0] raw;
    logic [W:0] red;

    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        red = raw - SW'(MODULUS);
        sum = (raw >= SW'(MODULUS)) ? red[W-1:0] : raw[W-1:0];
    end
endmodule

// File: rtl/mexp_consts.sv
module mexp_consts #(
    parameter int W       = 4,
    parameter int STAGES  = 8,
    parameter int MODULUS = 15,
    parameter int BASE    = 7,
    localparam int IDX_W  = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             use_inv,
    output logic [W-1:0]     k
);
    logic [W-1:0] fwd_tab [STAGES];
    logic [W-1:0] inv_tab [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        localparam longint FWD = mexp_pkg::stage_const(BASE, g, MODULUS);
        localparam longint INV = mexp_pkg::inv_mod(FWD, MODULUS);
        assign fwd_tab[g] = W'(FWD);
        assign inv_tab[g] = W'(INV);
    end

    always_comb begin
        k = use_inv ? inv_tab[idx] : fwd_tab[idx];
    end
endmodule

// File: rtl/mexp_mulunit.sv
module mexp_mulunit #(
    parameter int W       = 4,
    parameter int MODULUS = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         ctrl,
    input  logic [W-1:0] operand,
    input  logic [W-1:0] k,
    output logic         done,
    output logic [W-1:0] res
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [W-1:0]  acc;
        logic [W-1:0]  addend;
        logic [W-1:0]  opnd;
        logic          ctl;
        logic          done;
        logic [W-1:0]  res;
    } mul_t;

    mul_t         q, n;
    logic [W-1:0] acc_sum;
    logic [W-1:0] dbl;

    mexp_modadd #(.W(W), .MODULUS(MODULUS)) u_acc (
        .a(q.acc), .b(q.addend), .sum(acc_sum)
    );

    mexp_modadd #(.W(W), .MODULUS(MODULUS)) u_dbl (
        .a(q.addend), .b(q.addend), .sum(dbl)
    );

    always_comb begin
        n      = q;
        n.done = 1'b0;
        if (go && !q.busy) begin
            n.busy   = 1'b1;
            n.cnt    = '0;
            n.acc    = '0;
            n.addend = k;
            n.opnd   = operand;
            n.ctl    = ctrl;
        end else if (q.busy) begin
            if (q.opnd[q.cnt]) n.acc = acc_sum;
            n.addend = dbl;
            n.cnt    = q.cnt + 1'b1;
            if (q.cnt == CW'(W - 1)) begin
                n.busy = 1'b0;
                n.done = 1'b1;
                if (q.ctl) n.res = q.opnd[q.cnt] ? acc_sum : q.acc;
                else       n.res = q.opnd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign done = q.done;
    assign res  = q.res;
endmodule

// File: rtl/mexp_top.sv
module mexp_top #(
    parameter int MOD_W   = 4,
    parameter int MODULUS = 15,
    parameter int BASE    = 7,
    localparam int STAGES = 2 * MOD_W,
    localparam int EXP_W  = STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [EXP_W-1:0] exponent,
    output logic             busy,
    output logic             done,
    output logic [MOD_W-1:0] result,
    output logic             step_valid,
    output logic [MOD_W-1:0] scratch
);
    import mexp_pkg::*;

    localparam int IDX_W = (STAGES > 1) ? $clog2(STAGES) : 1;
    localparam int ONE   = (MODULUS > 1) ? 1 : 0;

    typedef struct packed {
        phase_e           ph;
        logic [EXP_W-1:0] x;
        logic [IDX_W-1:0] stg;
        logic [MOD_W-1:0] z;
        logic [MOD_W-1:0] scr;
        logic             go;
        logic             busy;
        logic             done;
        logic             step;
    } seq_t;

    seq_t             q, n;
    logic [MOD_W-1:0] k_sel;
    logic             mul_done;
    logic [MOD_W-1:0] mul_res;

    function automatic logic [MOD_W-1:0] sub_mod(input logic [MOD_W-1:0] a,
                                                 input logic [MOD_W-1:0] b);
        logic [MOD_W:0] t;
        if (a >= b) t = {1'b0, a} - {1'b0, b};
        else        t = {1'b0, a} + (MOD_W+1)'(MODULUS) - {1'b0, b};
        return t[MOD_W-1:0];
    endfunction

    mexp_consts #(.W(MOD_W), .STAGES(STAGES), .MODULUS(MODULUS), .BASE(BASE)) u_consts (
        .idx     (q.stg),
        .use_inv (q.ph == PH_BACK),
        .k       (k_sel)
    );

    mexp_mulunit #(.W(MOD_W), .MODULUS(MODULUS)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (q.go),
        .ctrl    (q.x[q.stg]),
        .operand (q.z),
        .k       (k_sel),
        .done    (mul_done),
        .res     (mul_res)
    );

    always_comb begin
        n      = q;
        n.go   = 1'b0;
        n.done = 1'b0;
        n.step = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    n.ph   = PH_FWD;
                    n.x    = exponent;
                    n.stg  = '0;
                    n.z    = MOD_W'(ONE);
                    n.scr  = '0;
                    n.go   = 1'b1;
                    n.busy = 1'b1;
                end
            end
            PH_FWD: begin
                if (mul_done) begin
                    // product becomes the working value, old value parks in scratch
                    n.z   = mul_res;
                    n.scr = q.z;
                    n.ph  = PH_BACK;
                    n.go  = 1'b1;
                end
            end
            PH_BACK: begin
                if (mul_done) begin
                    n.scr  = sub_mod(q.scr, mul_res);
                    n.step = 1'b1;
                    if (q.stg == IDX_W'(STAGES - 1)) begin
                        n.ph   = PH_IDLE;
                        n.busy = 1'b0;
                        n.done = 1'b1;
                    end else begin
                        n.stg = q.stg + 1'b1;
                        n.ph  = PH_FWD;
                        n.go  = 1'b1;
                    end
                end
            end
            default: n.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy       = q.busy;
    assign done       = q.done;
    assign result     = q.z;
    assign step_valid = q.step;
    assign scratch    = q.scr;
endmodule

// File: rtl/mexp_chk.sv
module mexp_chk #(
    parameter int MOD_W   = 4,
    parameter int MODULUS = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             step_valid,
    input logic [MOD_W-1:0] result,
    input logic [MOD_W-1:0] scratch
);
    localparam int STAGES = 2 * MOD_W;
    localparam int SC_W   = $clog2(STAGES + 1);

    logic [SC_W-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                seen_q <= '0;
        else if (start && !busy)   seen_q <= '0;
        else if (step_valid)       seen_q <= seen_q + 1'b1;
    end

    AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> step_valid && (int'(seen_q) == STAGES - 1));                 // R3
    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> int'(seen_q) < STAGES);                                // R3
    AST_SCRATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> scratch == '0);                                        // R4
    AST_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(result) < MODULUS) && (int'(scratch) < MODULUS));               // R8
    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);                                             // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                      // R7
    AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy || done);                                      // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(result));                                 // R9
endmodule

bind mexp_top mexp_chk #(.MOD_W(MOD_W), .MODULUS(MODULUS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .step_valid (step_valid),
    .result     (result),
    .scratch    (scratch)
);

// File: tb/sim_mexp_top.sv
module sim_mexp_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // copy 0: modulus 15, base 7, 4-bit; copy 1: modulus 21, base 5, 5-bit
    logic       st0 = 1'b0, st1 = 1'b0;
    logic [7:0] x0 = '0;
    logic [9:0] x1 = '0;
    logic       busy0, done0, stp0, busy1, done1, stp1;
    logic [3:0] res0, scr0;
    logic [4:0] res1, scr1;

    mexp_top #(.MOD_W(4), .MODULUS(15), .BASE(7)) u0 (
        .clk(clk), .rst_n(rst_n), .start(st0), .exponent(x0), .busy(busy0),
        .done(done0), .result(res0), .step_valid(stp0), .scratch(scr0)
    );
    mexp_top #(.MOD_W(5), .MODULUS(21), .BASE(5)) u1 (
        .clk(clk), .rst_n(rst_n), .start(st1), .exponent(x1), .busy(busy1),
        .done(done1), .result(res1), .step_valid(stp1), .scratch(scr1)
    );

    int errs = 0;
    int checks = 0;
    int lat_ref [2] = '{-1, -1};

    localparam int NVEC = 16;
    localparam int VEC_X [NVEC] = '{0, 1, 2, 3, 5, 6, 7, 64, 100, 255,
                                    511, 512, 682, 1000, 1022, 1023};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_pow(input int y, input int x, input int m);
        int r = 1 % m;
        for (int i = 0; i < x; i++) r = (r * y) % m;
        return r;
    endfunction

    task automatic launch(input int w, input int x);
        @(negedge clk);
        if (w == 0) begin st0 = 1'b1; x0 = 8'(x); end
        else        begin st1 = 1'b1; x1 = 10'(x); end
        @(negedge clk);
        st0 = 1'b0;
        st1 = 1'b0;
    endtask

    // waits for done; counts strobes, nonzero scratch strobes and cycles
    task automatic await(input int w, output int res, output int steps,
                         output int zbad, output int cyc);
        steps = 0; zbad = 0; cyc = 1; res = 0;
        while (1) begin
            logic s, d;
            int sc;
            if (w == 0) begin s = stp0; d = done0; sc = int'(scr0); res = int'(res0); end
            else        begin s = stp1; d = done1; sc = int'(scr1); res = int'(res1); end
            if (s) begin steps++; if (sc != 0) zbad++; end
            if (d) break;
            if (cyc > 3000) begin
                check(1'b0, "R3 run timeout", cyc, 0);
                break;
            end
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic full_run(input int w, input int x);
        int res, steps, zbad, cyc, m, y, nst;
        m   = (w == 0) ? 15 : 21;
        y   = (w == 0) ? 7 : 5;
        nst = (w == 0) ? 8 : 10;
        launch(w, x);
        await(w, res, steps, zbad, cyc);
        check(res == ref_pow(y, x, m), "R2 power result", res, ref_pow(y, x, m));
        check(steps == nst, "R3 stage strobes", steps, nst);
        check(zbad == 0, "R4 scratch zero at strobe", zbad, 0);
        check(res < m, "R8 result below modulus", res, m - 1);
        if (lat_ref[w] < 0) lat_ref[w] = cyc;
        check(cyc == lat_ref[w], "R6 constant latency", cyc, lat_ref[w]);
    endtask

    initial begin
        #(150000 * 10);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int res, steps, zbad, cyc, held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy0 && !done0 && !stp0, "R1 copy0 flags", int'({busy0, done0, stp0}), 0);
        check(res0 == 0 && scr0 == 0, "R1 copy0 regs", int'(res0), 0);
        check(!busy1 && !done1 && !stp1, "R1 copy1 flags", int'({busy1, done1, stp1}), 0);
        check(res1 == 0 && scr1 == 0, "R1 copy1 regs", int'(res1), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table-driven: ten-stage copy
        for (int i = 0; i < NVEC; i++) full_run(1, VEC_X[i]);

        // exhaustive: eight-stage copy
        for (int x = 0; x < 256; x++) full_run(0, x);

        // R7: busy timing
        @(negedge clk);
        st0 = 1'b1; x0 = 8'd9;
        @(negedge clk);
        st0 = 1'b0;
        check(busy0 == 1'b1, "R7 busy after start", int'(busy0), 1);
        await(0, res, steps, zbad, cyc);
        check(busy0 == 1'b0, "R7 busy low at done", int'(busy0), 0);

        // R5: start during a run is ignored
        launch(0, 3);
        repeat (4) @(negedge clk);
        st0 = 1'b1; x0 = 8'd5;
        @(negedge clk);
        st0 = 1'b0;
        await(0, res, steps, zbad, cyc);
        check(res == ref_pow(7, 3, 15), "R5 ignored restart result", res, ref_pow(7, 3, 15));
        check(steps == 8 - 0 - 0 || steps < 8, "R5 no extra strobes", steps, 8);
        repeat (200) begin
            @(negedge clk);
            if (done0) check(1'b0, "R5 second done", 1, 0);
        end

        // R9: result holds while idle
        held = int'(res0);
        repeat (25) @(negedge clk);
        check(int'(res0) == held && !busy0, "R9 idle hold", int'(res0), held);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule